// File: doc/BRIEF.md
# Call-Frame Context and Local Stack Allocator

This block manages the procedure-call resources of a single process. A chain of execution contexts is prepared when the block comes out of reset. Each context has a fixed capacity and a link to the next context in the chain. When a call is requested, the block follows the link of the current context and checks the callee's size requirement against the capacity of the linked context. If the call is accepted, the block makes that context current and raises the process level by one.

While a call is active, the block also serves local allocation requests. Each request gets the next free slot of a descriptor table and the next free bytes of one contiguous storage pool. No free list is kept: both pointers only move forward. Every granted object carries the level it was allocated at.

When a call ends, the block restores the current context, both pool pointers and the level to the values they had when that call was accepted. This releases everything the callee allocated in one step. Every request gets its answer one cycle later, as a single grant pulse or a single fault pulse. A fault pulse comes with a cause code.

Top module: `call_frame_alloc`

## Requirements
- R1: After reset the current level is 1, context 0 is current, grant and fault are low, and the first allocation receives descriptor 0 at storage address 0.
- R2: A request is answered in the next cycle by exactly one of grant or fault; with no request neither pulses. When several requests are raised together, return wins over call, and call wins over allocate.
- R3: The context chain holds 16 contexts with ids 0 to 15, and context i links to context i+1. Context 15 has a null link, so a call made from context 15 faults with code 1.
- R4: The capacity of context i is 64 + 32*(i mod 4) bytes. A call whose requirement exceeds the capacity of the linked context faults with code 2 and changes no state.
- R5: An accepted call reports the new context on ctx_id and raises cur_level by exactly 1.
- R6: Allocations receive consecutive descriptor indices and storage addresses. The storage pointer advances by the requested size rounded up to a multiple of 4; a size of 0 consumes a descriptor but no bytes.
- R7: Each granted allocation reports obj_level equal to the current level.
- R8: An allocation faults with code 3 and leaves both pointers unchanged if either of these holds: its rounded end would exceed the 1024-byte pool, or all 64 descriptor slots are already in use.
- R9: A return reports the caller's context on ctx_id. It restores the level, the descriptor pointer and the storage pointer to their values when the matching call was accepted.
- R10: A return with no active call faults with code 4. A call when 16 frames are already saved faults with code 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_call | input | 1 | Call request |
| call_need | input | 11 | Context bytes the callee requires |
| req_ret | input | 1 | Return request |
| req_alloc | input | 1 | Local allocation request |
| alloc_bytes | input | 11 | Bytes requested for the allocation |
| grant | output | 1 | One-cycle pulse: request granted |
| fault | output | 1 | One-cycle pulse: request refused |
| fault_code | output | 3 | Cause of the last fault (1 null link, 2 context too small, 3 pool exhausted, 4 no frame, 5 frame store full) |
| ctx_id | output | 4 | Context made current by the last granted call or return |
| desc_idx | output | 6 | Descriptor slot of the last granted allocation |
| store_addr | output | 11 | Byte address of the last granted allocation |
| obj_level | output | 8 | Level stamped on the last granted allocation |
| cur_level | output | 8 | Current process level |

## Verification
The checker tests the following on every cycle:
- Each request gets exactly one answer, and no answer appears without a request.
- A granted call raises the level by one, and a granted return lowers it by one.
- A refused request leaves the level as it was.
- Allocations are stamped with the live level.

Some behaviours only the bench scenarios can show. These are the actual values of context ids, descriptor indices and storage addresses, the restoration of the pool pointers across nested calls and returns, the null link at the end of the chain, capacity refusals, and pool and descriptor exhaustion.

// File: rtl/cfa_pkg.sv
package cfa_pkg;

  typedef enum logic [2:0] {
    FLT_NONE        = 3'd0,
    FLT_NULL_LINK   = 3'd1,
    FLT_CTX_SMALL   = 3'd2,
    FLT_POOL_FULL   = 3'd3,
    FLT_RET_EMPTY   = 3'd4,
    FLT_FRAMES_FULL = 3'd5
  } fault_e;

  // Capacity of a preallocated context, cycling through four sizes.
  function automatic int unsigned ctx_capacity(int unsigned idx,
                                               int unsigned base,
                                               int unsigned step);
    return base + (idx % 4) * step;
  endfunction

endpackage

// File: rtl/cfa_ctx_chain.sv
module cfa_ctx_chain #(
  parameter int NUM_CTX  = 16,
  parameter int CAP_BASE = 64,
  parameter int CAP_STEP = 32,
  parameter int CW       = 4,
  parameter int AW       = 11
) (
  input  logic [CW-1:0] cur_ctx,
  output logic          nxt_valid,
  output logic [CW-1:0] nxt_id,
  output logic [AW-1:0] nxt_cap
);

  logic          link_ok [NUM_CTX];
  logic [CW-1:0] link_to [NUM_CTX];
  logic [AW-1:0] cap_tab [NUM_CTX];

  for (genvar i = 0; i < NUM_CTX; i++) begin : g_ent
    assign link_ok[i] = (i < NUM_CTX - 1) ? 1'b1 : 1'b0;
    assign link_to[i] = (i < NUM_CTX - 1) ? CW'(i + 1) : '0;
    assign cap_tab[i] = AW'(cfa_pkg::ctx_capacity(i, CAP_BASE, CAP_STEP));
  end

  always_comb begin
    nxt_valid = 1'b0;
    nxt_id    = '0;
    nxt_cap   = '0;
    if (int'(cur_ctx) < NUM_CTX) begin
      nxt_valid = link_ok[cur_ctx];
      nxt_id    = link_to[cur_ctx];
    end
    if (int'(nxt_id) < NUM_CTX) begin
      nxt_cap = cap_tab[nxt_id];
    end
  end

endmodule

// File: rtl/cfa_frame_lifo.sv
module cfa_frame_lifo #(
  parameter int DEPTH = 16,
  parameter int FW    = 32,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int NW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [FW-1:0] push_data,
  output logic [FW-1:0] top_data,
  output logic          full,
  output logic          empty
);

  logic [FW-1:0] mem [DEPTH];
  logic [NW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] wr_idx, top_idx;
  logic          do_push, do_pop;

  assign full    = (cnt_q == NW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign wr_idx  = PW'(cnt_q);
  assign top_idx = PW'(cnt_q - 1'b1);
  assign top_data = empty ? '0 : mem[top_idx];

  always_comb begin
    cnt_d = cnt_q;
    if (do_push)     cnt_d = cnt_q + 1'b1;
    else if (do_pop) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_idx] <= push_data;
  end

endmodule

// File: rtl/cfa_stack_pool.sv
module cfa_stack_pool #(
  parameter int DESC_SLOTS = 64,
  parameter int POOL_BYTES = 1024,
  parameter int AW         = 11,
  parameter int DPW        = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           alloc_go,
  input  logic           restore_go,
  input  logic [DPW-1:0] restore_dp,
  input  logic [AW-1:0]  restore_sp,
  input  logic [AW-1:0]  req_bytes,
  output logic           fits,
  output logic [DPW-1:0] dp_q,
  output logic [AW-1:0]  sp_q
);

  localparam int EW = AW + 2;

  logic [EW-1:0]  rounded, end_w;
  logic [DPW-1:0] dp_d;
  logic [AW-1:0]  sp_d;

  assign rounded = (EW'(req_bytes) + EW'(3)) & ~EW'(3);
  assign end_w   = EW'(sp_q) + rounded;
  assign fits    = (end_w <= EW'(POOL_BYTES)) && (dp_q < DPW'(DESC_SLOTS));

  always_comb begin
    dp_d = dp_q;
    sp_d = sp_q;
    if (restore_go) begin
      dp_d = restore_dp;
      sp_d = restore_sp;
    end else if (alloc_go) begin
      dp_d = dp_q + 1'b1;
      sp_d = AW'(end_w);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_q <= '0;
      sp_q <= '0;
    end else if (restore_go || alloc_go) begin
      dp_q <= dp_d;
      sp_q <= sp_d;
    end
  end

endmodule

// File: rtl/call_frame_alloc.sv
module call_frame_alloc #(
  parameter int NUM_CTX    = 16,
  parameter int CAP_BASE   = 64,
  parameter int CAP_STEP   = 32,
  parameter int FRAME_DEPTH = 16,
  parameter int DESC_SLOTS = 64,
  parameter int POOL_BYTES = 1024,
  parameter int LW         = 8,
  parameter int LEVEL_INIT = 1,
  localparam int CW  = $clog2(NUM_CTX),
  localparam int AW  = $clog2(POOL_BYTES + 1),
  localparam int DW  = $clog2(DESC_SLOTS),
  localparam int DPW = $clog2(DESC_SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_call,
  input  logic [AW-1:0] call_need,
  input  logic          req_ret,
  input  logic          req_alloc,
  input  logic [AW-1:0] alloc_bytes,
  output logic          grant,
  output logic          fault,
  output logic [2:0]    fault_code,
  output logic [CW-1:0] ctx_id,
  output logic [DW-1:0] desc_idx,
  output logic [AW-1:0] store_addr,
  output logic [LW-1:0] obj_level,
  output logic [LW-1:0] cur_level
);
  import cfa_pkg::*;

  // Frame layout: {context, descriptor ptr, storage ptr, level}
  localparam int FW     = CW + DPW + AW + LW;
  localparam int LV_LO  = 0;
  localparam int SP_LO  = LW;
  localparam int DP_LO  = LW + AW;
  localparam int CX_LO  = LW + AW + DPW;

  logic [CW-1:0]  cur_ctx_q, cur_ctx_d;
  logic [LW-1:0]  level_q, level_d;

  logic           nxt_valid;
  logic [CW-1:0]  nxt_id;
  logic [AW-1:0]  nxt_cap;

  logic [FW-1:0]  push_frame, top_frame;
  logic           lifo_full, lifo_empty;

  logic           pool_fits;
  logic [DPW-1:0] dp_cur;
  logic [AW-1:0]  sp_cur;

  logic           sel_call, sel_ret, sel_alloc, any_req;
  logic           call_ok, ret_ok, alloc_ok;
  fault_e         cause;

  logic           grant_q, fault_q;
  logic [2:0]     code_q;
  logic [CW-1:0]  ctx_out_q, ctx_out_d;
  logic [DW-1:0]  desc_q;
  logic [AW-1:0]  addr_q;
  logic [LW-1:0]  olvl_q;
  logic           ctx_out_en, alloc_out_en, code_en;

  cfa_ctx_chain #(
    .NUM_CTX (NUM_CTX),
    .CAP_BASE(CAP_BASE),
    .CAP_STEP(CAP_STEP),
    .CW      (CW),
    .AW      (AW)
  ) chain_i (
    .cur_ctx  (cur_ctx_q),
    .nxt_valid(nxt_valid),
    .nxt_id   (nxt_id),
    .nxt_cap  (nxt_cap)
  );

  cfa_frame_lifo #(
    .DEPTH(FRAME_DEPTH),
    .FW   (FW)
  ) frames_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (call_ok),
    .pop      (ret_ok),
    .push_data(push_frame),
    .top_data (top_frame),
    .full     (lifo_full),
    .empty    (lifo_empty)
  );

  cfa_stack_pool #(
    .DESC_SLOTS(DESC_SLOTS),
    .POOL_BYTES(POOL_BYTES),
    .AW        (AW),
    .DPW       (DPW)
  ) pool_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_go  (alloc_ok),
    .restore_go(ret_ok),
    .restore_dp(top_frame[DP_LO +: DPW]),
    .restore_sp(top_frame[SP_LO +: AW]),
    .req_bytes (alloc_bytes),
    .fits      (pool_fits),
    .dp_q      (dp_cur),
    .sp_q      (sp_cur)
  );

  assign push_frame = {cur_ctx_q, dp_cur, sp_cur, level_q};

  // Request arbitration: return, then call, then allocate.
  assign sel_ret   = req_ret;
  assign sel_call  = req_call && !req_ret;
  assign sel_alloc = req_alloc && !req_call && !req_ret;
  assign any_req   = req_ret || req_call || req_alloc;

  assign call_ok  = sel_call && !lifo_full && nxt_valid && (call_need <= nxt_cap);
  assign ret_ok   = sel_ret && !lifo_empty;
  assign alloc_ok = sel_alloc && pool_fits;

  always_comb begin
    cause = FLT_NONE;
    if (sel_ret && lifo_empty)           cause = FLT_RET_EMPTY;
    else if (sel_call && lifo_full)      cause = FLT_FRAMES_FULL;
    else if (sel_call && !nxt_valid)     cause = FLT_NULL_LINK;
    else if (sel_call && !call_ok)       cause = FLT_CTX_SMALL;
    else if (sel_alloc && !pool_fits)    cause = FLT_POOL_FULL;
  end

  // Next-state for the process state.
  always_comb begin
    cur_ctx_d = cur_ctx_q;
    level_d   = level_q;
    if (call_ok) begin
      cur_ctx_d = nxt_id;
      level_d   = level_q + 1'b1;
    end else if (ret_ok) begin
      cur_ctx_d = top_frame[CX_LO +: CW];
      level_d   = top_frame[LV_LO +: LW];
    end
  end

  assign ctx_out_en   = call_ok || ret_ok;
  assign ctx_out_d    = cur_ctx_d;
  assign alloc_out_en = alloc_ok;
  assign code_en      = any_req && (cause != FLT_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_ctx_q <= '0;
      level_q   <= LW'(LEVEL_INIT);
    end else if (ctx_out_en) begin
      cur_ctx_q <= cur_ctx_d;
      level_q   <= level_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      grant_q <= call_ok || ret_ok || alloc_ok;
      fault_q <= code_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= '0;
    else if (code_en) code_q <= 3'(cause);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ctx_out_q <= '0;
    else if (ctx_out_en) ctx_out_q <= ctx_out_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      desc_q <= '0;
      addr_q <= '0;
      olvl_q <= '0;
    end else if (alloc_out_en) begin
      desc_q <= DW'(dp_cur);
      addr_q <= sp_cur;
      olvl_q <= level_q;
    end
  end

  assign grant      = grant_q;
  assign fault      = fault_q;
  assign fault_code = code_q;
  assign ctx_id     = ctx_out_q;
  assign desc_idx   = desc_q;
  assign store_addr = addr_q;
  assign obj_level  = olvl_q;
  assign cur_level  = level_q;

endmodule

// File: rtl/cfa_checker.sv
module cfa_checker #(
  parameter int CW = 4,
  parameter int AW = 11,
  parameter int DW = 6,
  parameter int LW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_call,
  input logic [AW-1:0] call_need,
  input logic          req_ret,
  input logic          req_alloc,
  input logic [AW-1:0] alloc_bytes,
  input logic          grant,
  input logic          fault,
  input logic [2:0]    fault_code,
  input logic [CW-1:0] ctx_id,
  input logic [DW-1:0] desc_idx,
  input logic [AW-1:0] store_addr,
  input logic [LW-1:0] obj_level,
  input logic [LW-1:0] cur_level
);

  // R2
  single_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && fault));

  // R2
  answered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_call || req_ret || req_alloc) |=> (grant || fault));

  // R2
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_call || req_ret || req_alloc) |=> (!grant && !fault));

  // R5
  call_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_call && !req_ret) |=> (!grant || cur_level == LW'($past(cur_level) + 1'b1)));

  // R9
  ret_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ret |=> (!grant || cur_level == LW'($past(cur_level) - 1'b1)));

  // R7
  level_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_alloc && !req_call && !req_ret) |=> (!grant || obj_level == cur_level));

  // R4
  fault_keeps_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> $stable(cur_level));

endmodule

bind call_frame_alloc cfa_checker #(
  .CW(CW), .AW(AW), .DW(DW), .LW(LW)
) chk_i (.*);

// File: tb/call_frame_alloc_tb.sv
module call_frame_alloc_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_call = 1'b0, req_ret = 1'b0, req_alloc = 1'b0;
  logic [10:0] call_need = '0, alloc_bytes = '0;
  logic        grant, fault;
  logic [2:0]  fault_code;
  logic [3:0]  ctx_id;
  logic [5:0]  desc_idx;
  logic [10:0] store_addr;
  logic [7:0]  obj_level, cur_level;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  call_frame_alloc dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_call(req_call), .call_need(call_need),
    .req_ret(req_ret), .req_alloc(req_alloc), .alloc_bytes(alloc_bytes),
    .grant(grant), .fault(fault), .fault_code(fault_code),
    .ctx_id(ctx_id), .desc_idx(desc_idx), .store_addr(store_addr),
    .obj_level(obj_level), .cur_level(cur_level)
  );

  // Vector: {op[1:0] (0 alloc,1 call,2 ret), arg[10:0], code[2:0] (0 = grant),
  //          id[5:0] (ctx or desc), addr[10:0], level[7:0]}
  localparam int NV = 15;
  localparam logic [40:0] VEC [NV] = '{
    {2'd0, 11'd5,    3'd0, 6'd0,  11'd0,  8'd1},  // R6 round 5 -> 8
    {2'd0, 11'd4,    3'd0, 6'd1,  11'd8,  8'd1},  // R6
    {2'd1, 11'd96,   3'd0, 6'd1,  11'd0,  8'd2},  // R3 R4 R5 exact fit
    {2'd0, 11'd0,    3'd0, 6'd2,  11'd12, 8'd2},  // R6 zero bytes
    {2'd0, 11'd13,   3'd0, 6'd3,  11'd12, 8'd2},  // R6 R7
    {2'd1, 11'd129,  3'd2, 6'd0,  11'd0,  8'd2},  // R4 too large
    {2'd1, 11'd128,  3'd0, 6'd2,  11'd0,  8'd3},  // R4 R5
    {2'd0, 11'd1,    3'd0, 6'd4,  11'd28, 8'd3},  // R7
    {2'd2, 11'd0,    3'd0, 6'd1,  11'd0,  8'd2},  // R9
    {2'd0, 11'd2,    3'd0, 6'd4,  11'd28, 8'd2},  // R9 pointers restored
    {2'd2, 11'd0,    3'd0, 6'd0,  11'd0,  8'd1},  // R9
    {2'd0, 11'd3,    3'd0, 6'd2,  11'd12, 8'd1},  // R9
    {2'd2, 11'd0,    3'd4, 6'd0,  11'd0,  8'd1},  // R10 empty return
    {2'd0, 11'd1009, 3'd3, 6'd0,  11'd0,  8'd1},  // R8 end 1028
    {2'd0, 11'd1005, 3'd0, 6'd3,  11'd16, 8'd1}   // R8 unchanged, end 1024
  };

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic issue(int op, int arg);
    @(negedge clk);
    req_alloc = (op == 0); req_call = (op == 1); req_ret = (op == 2);
    alloc_bytes = 11'(arg); call_need = 11'(arg);
    @(negedge clk);
    req_alloc = 1'b0; req_call = 1'b0; req_ret = 1'b0;
  endtask

  task automatic expect_answer(string tag, int op, int code, int id, int addr, int lvl);
    if (code == 0) begin
      check({tag, " grant"}, int'(grant), 1);
      check({tag, " fault"}, int'(fault), 0);
      if (op == 0) begin
        check({tag, " desc_idx"}, int'(desc_idx), id);
        check({tag, " store_addr"}, int'(store_addr), addr);
        check({tag, " obj_level"}, int'(obj_level), lvl);
      end else begin
        check({tag, " ctx_id"}, int'(ctx_id), id);
      end
    end else begin
      check({tag, " fault"}, int'(fault), 1);
      check({tag, " grant"}, int'(grant), 0);
      check({tag, " fault_code"}, int'(fault_code), code);
    end
    check({tag, " cur_level"}, int'(cur_level), lvl);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 grant", int'(grant), 0);
    check("R1 fault", int'(fault), 0);
    check("R1 cur_level", int'(cur_level), 1);

    for (int v = 0; v < NV; v++) begin
      issue(int'(VEC[v][40:39]), int'(VEC[v][38:28]));
      expect_answer($sformatf("vec%0d", v), int'(VEC[v][40:39]), int'(VEC[v][27:25]),
                    int'(VEC[v][24:19]), int'(VEC[v][18:8]), int'(VEC[v][7:0]));
    end

    // R2 idle cycle: no pulses
    @(negedge clk);
    check("R2 idle grant", int'(grant), 0);
    check("R2 idle fault", int'(fault), 0);

    // R1 after reset the first allocation gets slot 0 at address 0
    do_reset();
    issue(0, 7);
    expect_answer("R1 first alloc", 0, 0, 0, 0, 1);

    // R2 priority: return beats call with no frame saved -> code 4
    @(negedge clk);
    req_ret = 1'b1; req_call = 1'b1; call_need = 11'd10;
    @(negedge clk);
    req_ret = 1'b0; req_call = 1'b0;
    expect_answer("R2 ret over call", 2, 4, 0, 0, 1);

    // R2 priority: call beats alloc
    @(negedge clk);
    req_call = 1'b1; req_alloc = 1'b1; call_need = 11'd10; alloc_bytes = 11'd4;
    @(negedge clk);
    req_call = 1'b0; req_alloc = 1'b0;
    expect_answer("R2 call over alloc", 1, 0, 1, 0, 2);
    issue(0, 4);
    expect_answer("R2 alloc untouched", 0, 0, 1, 8, 2);

    // R3 walk the chain to its null link
    do_reset();
    for (int i = 1; i < 16; i++) begin
      issue(1, 64);
      expect_answer($sformatf("R3 call%0d", i), 1, 0, i, 0, 1 + i);
    end
    issue(1, 0);
    expect_answer("R3 null link", 1, 1, 0, 0, 16);
    for (int i = 14; i >= 0; i--) begin
      issue(2, 0);
      expect_answer($sformatf("R9 unwind%0d", i), 2, 0, i, 0, 1 + i);
    end
    issue(2, 0);
    expect_answer("R10 unwound", 2, 4, 0, 0, 1);

    // R8 descriptor slot exhaustion
    do_reset();
    for (int i = 0; i < 64; i++) begin
      issue(0, 0);
      expect_answer($sformatf("R8 slot%0d", i), 0, 0, i, 0, 1);
    end
    issue(0, 0);
    expect_answer("R8 slots exhausted", 0, 3, 0, 0, 1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule